// File: doc/BRIEF.md
# Saturating Dual Event Counter Unit

This block gathers performance statistics for a level-2 cache controller. Two identical 32-bit counters each pick one cache event line through their own configuration register and add one on every clock in which that line pulses. A single control register gates all counting. Software reaches every register over a plain 32-bit register bus with byte address, write enable, write data and combinational read data.

The counters never wrap. A counter that reaches all-ones stays there, so software is expected to sample it and write it back to zero often enough to avoid losing events. The per-counter registers are placed with counter 1 at the lower address of each pair. A parameter selects between the base controller, which offers event codes 1 to 9, and the extended controller, which adds codes 10 to 15.

Top module: `cache_evt_counters`

## Requirements
- R1: After reset, every mapped register reads as zero: the control word, both configuration words and both counter values.
- R2: A counter at 0xFFFFFFFF stays at 0xFFFFFFFF when further events arrive. It does not wrap.
- R3: Byte addresses: control 0x00, configuration of counter 1 at 0x04, configuration of counter 0 at 0x08, value of counter 1 at 0x0C, value of counter 0 at 0x10.
- R4: Bit 0 of the control word is the global enable. While it is 0, neither counter changes except through a bus write.
- R5: All 32 bits of the control word are stored and read back exactly as written.
- R6: A configuration word holds the event source in bits [5:2] and a stored interrupt-disable flag in bit 0. All other bits read as zero. Source 0 stops that counter.
- R7: Input line evt_in[k] carries event code k (bit 0 is never selected). With the global enable set and a source of k, the counter adds exactly one in each cycle that evt_in[k] is high.
- R8: Writing a counter value register loads the written value. When the write and a counted event fall in the same cycle, the write wins.
- R9: With HAS_EXT = 0, sources 10 to 15 never advance the counter. With HAS_EXT = 1 they count like the other codes.
- R10: A read from an unmapped or unaligned address returns zero. A write to one changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe, committed on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| evt_in | input | 16 | Single-cycle event pulses, bit k is event code k |

## Verification
On every cycle the checker enforces the counter update rules: a saturated counter holds, a counter moves by zero or one, it holds while counting is gated off or its source is zero, a write loads exactly the written data, base-variant counters ignore extended codes, and unmapped reads return zero. The exact counts, the placement of counter 1 below counter 0, the readback of the control and configuration words, and the contrast between the two variants on the same extended code can only be shown by the bench. It runs a base-variant copy next to the extended one and gives both the same stimulus.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  localparam int DATA_W      = 32;
  localparam int SRC_W       = 4;
  localparam int EVT_W       = 1 << SRC_W;
  localparam int BASE_MAX    = 9;
  localparam int SRC_LSB     = 2;
  localparam int IRQDIS_BIT  = 0;
  localparam int EN_BIT      = 0;
  localparam int CTRL_ADDR   = 0;
  localparam int PAIR_BASE   = 4;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [SRC_W-1:0]  src_t;

  // Saturating increment: all-ones sticks.
  function automatic word_t sat_inc(word_t v);
    return (v == '1) ? v : v + word_t'(1);
  endfunction

  // Is a source code able to count on this variant?
  function automatic logic src_allowed(src_t s, bit ext);
    return (s != '0) && (ext || (int'(s) <= BASE_MAX));
  endfunction

  // Byte address of the per-counter register of kind 'kind' (0 = config,
  // 1 = value) for counter 'idx'; counter NUM_CNT-1 sits lowest.
  function automatic int pair_addr(int kind, int idx, int num_cnt);
    return PAIR_BASE + 4 * (kind * num_cnt + (num_cnt - 1 - idx));
  endfunction

  function automatic word_t cfg_word(src_t s, logic irqdis);
    word_t w;
    w = '0;
    w[SRC_LSB +: SRC_W] = s;
    w[IRQDIS_BIT] = irqdis;
    return w;
  endfunction
endpackage

// File: rtl/cpc_regdec.sv
module cpc_regdec
  import cpc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_CNT = 2
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic               ctrl_sel,
  output logic [NUM_CNT-1:0] cfg_sel,
  output logic [NUM_CNT-1:0] val_sel,
  output logic               hit
);
  assign ctrl_sel = (addr == ADDR_W'(CTRL_ADDR));

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_dec
    localparam int CfgA = pair_addr(0, i, NUM_CNT);
    localparam int ValA = pair_addr(1, i, NUM_CNT);
    assign cfg_sel[i] = (addr == ADDR_W'(CfgA));
    assign val_sel[i] = (addr == ADDR_W'(ValA));
  end

  assign hit = ctrl_sel | (|cfg_sel) | (|val_sel);
endmodule

// File: rtl/cpc_evsel.sv
module cpc_evsel
  import cpc_pkg::*;
#(
  parameter bit HAS_EXT = 1'b1
) (
  input  src_t             src,
  input  logic [EVT_W-1:0] evt_in,
  output logic             ev_hit
);
  assign ev_hit = src_allowed(src, HAS_EXT) && evt_in[src];
endmodule

// File: rtl/cpc_counter.sv
module cpc_counter
  import cpc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ld,
  input  word_t ld_val,
  input  logic  inc,
  output word_t cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (ld)  cnt <= ld_val;
    else if (inc) cnt <= sat_inc(cnt);
  end
endmodule

// File: rtl/cache_evt_counters.sv
module cache_evt_counters
  import cpc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_CNT = 2,
  parameter bit HAS_EXT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [15:0]       evt_in
);
  logic                           ctrl_sel, addr_hit;
  logic [NUM_CNT-1:0]             cfg_sel, val_sel;
  word_t                          ctrl_q;
  logic                           glob_en;
  logic [NUM_CNT-1:0][SRC_W-1:0]  src_q;
  logic [NUM_CNT-1:0]             irqdis_q;
  logic [NUM_CNT-1:0][DATA_W-1:0] cnt_val;
  logic [NUM_CNT-1:0]             cnt_ld;
  logic [NUM_CNT-1:0]             ev_hit;
  logic [NUM_CNT-1:0]             cnt_inc;

  cpc_regdec #(.ADDR_W(ADDR_W), .NUM_CNT(NUM_CNT)) u_dec (
    .addr(bus_addr), .ctrl_sel(ctrl_sel), .cfg_sel(cfg_sel),
    .val_sel(val_sel), .hit(addr_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ctrl_q <= '0;
    else if (bus_we && ctrl_sel) ctrl_q <= bus_wdata;
  end
  assign glob_en = ctrl_q[EN_BIT];

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_q[i]    <= '0;
        irqdis_q[i] <= 1'b0;
      end else if (bus_we && cfg_sel[i]) begin
        src_q[i]    <= bus_wdata[SRC_LSB +: SRC_W];
        irqdis_q[i] <= bus_wdata[IRQDIS_BIT];
      end
    end

    cpc_evsel #(.HAS_EXT(HAS_EXT)) u_sel (
      .src(src_q[i]), .evt_in(evt_in), .ev_hit(ev_hit[i])
    );

    assign cnt_ld[i]  = bus_we && val_sel[i];
    assign cnt_inc[i] = glob_en && ev_hit[i];

    cpc_counter u_ctr (
      .clk(clk), .rst_n(rst_n), .ld(cnt_ld[i]), .ld_val(bus_wdata),
      .inc(cnt_inc[i]), .cnt(cnt_val[i])
    );
  end

  always_comb begin
    bus_rdata = ctrl_sel ? ctrl_q : '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (cfg_sel[i]) bus_rdata = bus_rdata | cfg_word(src_q[i], irqdis_q[i]);
      if (val_sel[i]) bus_rdata = bus_rdata | cnt_val[i];
    end
  end
endmodule

// File: rtl/cpc_checker.sv
module cpc_checker
  import cpc_pkg::*;
#(
  parameter int NUM_CNT = 2,
  parameter bit HAS_EXT = 1'b1
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           glob_en,
  input logic [NUM_CNT-1:0][DATA_W-1:0] cnt_val,
  input logic [NUM_CNT-1:0]             cnt_ld,
  input logic [NUM_CNT-1:0][SRC_W-1:0]  src_q,
  input logic [DATA_W-1:0]              ld_data,
  input logic                           addr_hit,
  input logic [DATA_W-1:0]              rdata
);
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
    p_sat_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_val[i] == '1 && !cnt_ld[i]) |=> (cnt_val[i] == '1));

    p_gate_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!glob_en && !cnt_ld[i]) |=> $stable(cnt_val[i]));

    p_src_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (src_q[i] == '0 && !cnt_ld[i]) |=> $stable(cnt_val[i]));

    p_step_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_ld[i] |=> ((cnt_val[i] == $past(cnt_val[i])) ||
                      (cnt_val[i] == $past(cnt_val[i]) + 32'd1)));

    p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_ld[i] |=> (cnt_val[i] == $past(ld_data)));

    if (!HAS_EXT) begin : g_base
      p_no_ext_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(src_q[i]) > BASE_MAX && !cnt_ld[i]) |=> $stable(cnt_val[i]));
    end
  end

  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |-> (rdata == '0));
endmodule

bind cache_evt_counters cpc_checker #(.NUM_CNT(NUM_CNT), .HAS_EXT(HAS_EXT)) u_chk (
  .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .cnt_val(cnt_val),
  .cnt_ld(cnt_ld), .src_q(src_q), .ld_data(bus_wdata),
  .addr_hit(addr_hit), .rdata(bus_rdata)
);

// File: tb/cache_evt_counters_tb.sv
module cache_evt_counters_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'h00, A_CFG1 = 8'h04, A_CFG0 = 8'h08,
                         A_VAL1 = 8'h0C, A_VAL0 = 8'h10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0, rdata_x, rdata_b;
  logic [15:0] evt_in = '0;
  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct { logic [7:0] addr; logic [31:0] exp; bit base; string tag; } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_evt_counters #(.HAS_EXT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_x), .evt_in(evt_in));

  cache_evt_counters #(.HAS_EXT(1'b0)) u_dut_base (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .evt_in(evt_in));

  // Monitor: pops at the falling edge after the read was set up.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      act = it.base ? rdata_b : rdata_x;
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s addr=%h base=%0d actual=%h expected=%h",
                 it.tag, it.addr, it.base, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    step();
    bus_we = 1'b0;
  endtask

  task automatic wr_evt(input logic [7:0] a, input logic [31:0] d, input int code);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d; evt_in = 16'(1) << code;
    step();
    bus_we = 1'b0; evt_in = '0;
  endtask

  task automatic pulse(input logic [15:0] mask, input int n);
    evt_in = mask;
    repeat (n) step();
    evt_in = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input bit base, input string tag);
    item_t it;
    bus_addr = a;
    it.addr = a; it.exp = e; it.base = base; it.tag = tag;
    sb_q.push_back(it);
    step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    // R1: reset state
    rd(A_CTRL, 32'h0, 0, "R1"); rd(A_CFG1, 32'h0, 0, "R1"); rd(A_CFG0, 32'h0, 0, "R1");
    rd(A_VAL1, 32'h0, 0, "R1"); rd(A_VAL0, 32'h0, 0, "R1"); rd(A_VAL0, 32'h0, 1, "R1");
    // R5 readback with enable clear; R4 no counting while gated
    wr(A_CTRL, 32'hA5A5_0000);
    rd(A_CTRL, 32'hA5A5_0000, 0, "R5");
    wr(A_CFG0, 32'h0000_000C);
    pulse(16'h0008, 4);
    rd(A_VAL0, 32'd0, 0, "R4");
    // R7 counting, R6 source zero
    wr(A_CTRL, 32'hA5A5_0001);
    rd(A_CTRL, 32'hA5A5_0001, 0, "R5");
    pulse(16'h0008, 4);
    rd(A_VAL0, 32'd4, 0, "R7");
    rd(A_VAL1, 32'd0, 0, "R6");
    wr(A_CFG1, 32'hFFFF_FFFF);
    rd(A_CFG1, 32'h0000_003D, 0, "R6");
    wr(A_CFG1, 32'h0000_0005);
    rd(A_CFG1, 32'h0000_0005, 0, "R6");
    // R3 ordering: counter 1 on code 1, counter 0 on code 3
    pulse(16'h000A, 2);
    rd(A_VAL1, 32'd2, 0, "R3");
    rd(A_VAL0, 32'd6, 0, "R3");
    pulse(16'h0004, 3);
    rd(A_VAL0, 32'd6, 0, "R7");
    rd(A_VAL1, 32'd2, 0, "R7");
    // R2 saturation
    wr(A_VAL1, 32'hFFFF_FFFD);
    rd(A_VAL1, 32'hFFFF_FFFD, 0, "R8");
    pulse(16'h0002, 5);
    rd(A_VAL1, 32'hFFFF_FFFF, 0, "R2");
    rd(A_VAL1, 32'hFFFF_FFFF, 1, "R2");
    // R8 write beats a same-cycle event
    wr_evt(A_VAL0, 32'd100, 3);
    rd(A_VAL0, 32'd100, 0, "R8");
    rd(A_VAL0, 32'd100, 1, "R8");
    // R9 extended code 11
    wr(A_CFG0, 32'h0000_002C);
    pulse(16'h0800, 3);
    rd(A_VAL0, 32'd103, 0, "R9");
    rd(A_VAL0, 32'd100, 1, "R9");
    // R10 unmapped access
    wr(8'h14, 32'h55);
    rd(8'h14, 32'h0, 0, "R10");
    wr(8'h11, 32'h0);
    rd(A_VAL0, 32'd103, 0, "R10");
    rd(8'h02, 32'h0, 0, "R10");
    rd(A_CTRL, 32'hA5A5_0001, 0, "R10");
    // R4 gate off again
    wr(A_CTRL, 32'hA5A5_0000);
    pulse(16'h0800, 2);
    rd(A_VAL0, 32'd103, 0, "R4");
    while (sb_q.size() > 0) step();
    step();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule